// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block is the hardware half of a transmit descriptor ring. It holds a small ring of descriptors. Each descriptor has a 16-bit status/control halfword, a 16-bit length and a 32-bit buffer address. Software fills descriptors through a host register port. It hands an entry to hardware by setting the entry's ready flag. It then writes the doorbell register so the engine starts looking again.

The engine walks the ring from its current position. It passes each ready entry to a frame sender over a valid/ready handshake. It then waits for the sender's completion report. The report is written back into the entry's status halfword, with the ready flag cleared. Completion raises a frame event or a buffer event in a write-one-to-clear event register. A mask register selects which events drive the interrupt line. Buffer contents never pass through the block; only the address and length go to the sender.

The walker has five named states:
- IDLE waits for a latched doorbell.
- SCAN examines the entry at the ring index. It moves to SEND if the entry is ready and returns to IDLE otherwise.
- SEND holds the request until the sender accepts it (SEND to WAIT).
- WAIT holds until the completion pulse arrives (WAIT to WBACK).
- WBACK writes the status back, raises events, advances the index and always moves to SCAN.

Top module: `txbd_ring_engine`

Host address map (HADDR_W = IDX_W+2 bits):
- The top address bit selects the control region (1) or the descriptor region (0).
- In the descriptor region, bits [IDX_W:1] give the entry index. Bit 0 selects the word: 0 is {status[15:0], length[15:0]} and 1 is the buffer address.
- In the control region, the low IDX_W+1 bits select the register: 0 is events, 1 is the mask, 2 is the doorbell.

Status halfword layout:
- bit 15: ready
- bit 14: spare, kept as written
- bit 13: wrap
- bit 12: interrupt-on-completion
- bit 11: last buffer of frame
- bit 10: append CRC
- bit 9: heartbeat error
- bit 8: late collision
- bit 7: retry limit exceeded
- bit 6: underrun
- bit 5: carrier lost
- bit 1: deferred
- all other bits: zero

## Requirements
- R1: After synchronous reset, the following all hold: the ring index is 0, `irq` and `snd_valid` are low, the event register reads 0, and every descriptor status reads 0 (no entry ready).
- R2: A write of any value to control register 2 (the doorbell) makes an idle engine scan again. An entry armed while the engine is idle, with no doorbell written, is not sent and keeps its ready bit.
- R3: When the entry at the ring index has status bit 15 set, the engine presents that entry's buffer address and length on `snd_addr`/`snd_len`. It also drives `snd_last` from status bit 11 and `snd_crc` from status bit 10.
- R4: When the entry at the ring index has bit 15 clear, the engine returns to idle. It sends nothing, and the ring index does not change.
- R5: On completion, the entry's status is rewritten as follows: bit 15 is cleared, and bits 14..10 are kept. `cmp_flags[5:1]` (heartbeat, late collision, retry limit, underrun, carrier lost) go to bits 9..5, and `cmp_flags[0]` (deferred) goes to bit 1. The length and address words are unchanged.
- R6: After an entry completes, the ring index becomes 0 if the entry had wrap bit 13 set. Otherwise it becomes index+1, wrapping to 0 after the last physical entry.
- R7: One doorbell drains every consecutively ready entry, up to a completely full ring, and stops at the first entry not ready.
- R8: Completion of an entry with bit 12 set sets event bit 27 if the entry had bit 11 set, and sets event bit 26 otherwise. An entry with bit 12 clear sets no event. No other event bit is ever set.
- R9: Writing the event register clears exactly the bits written as one.
- R10: `irq` is high exactly when some event bit is set and its mask bit (control register 1) is set.
- R11: While `snd_valid` is high and `snd_ready` is low, `snd_valid`, `snd_addr` and `snd_len` hold steady on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | HADDR_W | Host write address |
| host_wdata | input | 32 | Host write data |
| host_raddr | input | HADDR_W | Host read address |
| host_rdata | output | 32 | Host read data (combinational) |
| snd_valid | output | 1 | Descriptor offered to frame sender |
| snd_ready | input | 1 | Sender accepts the offered descriptor |
| snd_addr | output | 32 | Buffer address of the offered descriptor |
| snd_len | output | 16 | Buffer length of the offered descriptor |
| snd_last | output | 1 | Offered buffer ends a frame |
| snd_crc | output | 1 | Sender should append CRC |
| cmp_valid | input | 1 | Sender completion pulse |
| cmp_flags | input | 6 | Completion flags {hb, lc, rl, un, cs, def} |
| ring_idx | output | IDX_W | Hardware consumer index |
| irq | output | 1 | Masked event interrupt |

## Verification
The hardest situation to reach from the ports is a completely full ring. In that state the software producer index equals `ring_idx`, and only the ready bits distinguish the full ring from an empty one. The stimulus arms every entry after the engine has come to rest mid-ring. It then rings the doorbell once and checks three things: the engine serves all entries in order across the physical end of the ring, it stops where it started, and it leaves no entry ready. A second difficult point is showing that arming alone does nothing. The bench arms an entry while the engine is idle, watches `snd_valid` for many cycles and reads the entry back still ready. Only then does it write the doorbell.

// File: rtl/txr_pkg.sv
package txr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCAN,
        ST_SEND,
        ST_WAIT,
        ST_WBACK
    } txr_state_e;

    localparam int SB_READY = 15;
    localparam int SB_WRAP  = 13;
    localparam int SB_IRQ   = 12;
    localparam int SB_LAST  = 11;
    localparam int SB_CRC   = 10;
    localparam int SB_DEF   = 1;
    localparam int CTRL_LO  = 10;

    localparam int EV_FRAME = 27;
    localparam int EV_BUF   = 26;

    localparam int CR_EVENT = 0;
    localparam int CR_MASK  = 1;
    localparam int CR_BELL  = 2;

endpackage

// File: rtl/txr_desc_mem.sv
module txr_desc_mem #(
    parameter int DEPTH = 16,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             h_we,
    input  logic [IDX_W-1:0] h_idx,
    input  logic             h_word,
    input  logic [31:0]      h_wdata,
    input  logic [IDX_W-1:0] h_ridx,
    input  logic             h_rword,
    output logic [31:0]      h_rdata,
    input  logic             e_we,
    input  logic [IDX_W-1:0] e_idx,
    input  logic [15:0]      e_status,
    output logic [5:0]       e_ctrl,
    output logic [15:0]      e_len,
    output logic [31:0]      e_addr
);
    logic [15:0] st_q  [DEPTH];
    logic [15:0] len_q [DEPTH];
    logic [31:0] ba_q  [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                st_q[g]  <= '0;
                len_q[g] <= '0;
                ba_q[g]  <= '0;
            end else begin
                if (h_we && h_idx == IDX_W'(g)) begin
                    if (h_word) begin
                        ba_q[g] <= h_wdata;
                    end else begin
                        st_q[g]  <= h_wdata[31:16];
                        len_q[g] <= h_wdata[15:0];
                    end
                end
                // engine write-back wins over a same-cycle host write
                if (e_we && e_idx == IDX_W'(g)) begin
                    st_q[g] <= e_status;
                end
            end
        end
    end

    always_comb begin
        h_rdata = h_rword ? ba_q[h_ridx] : {st_q[h_ridx], len_q[h_ridx]};
        e_ctrl  = st_q[e_idx][15:10];
        e_len   = len_q[e_idx];
        e_addr  = ba_q[e_idx];
    end
endmodule

// File: rtl/txr_events.sv
module txr_events
    import txr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        set_frame,
    input  logic        set_buf,
    input  logic        clr_we,
    input  logic [31:0] clr_data,
    input  logic        mask_we,
    input  logic [31:0] mask_data,
    output logic [31:0] ev_q,
    output logic [31:0] mask_q,
    output logic        irq
);
    logic [31:0] set_vec;
    logic [31:0] clr_vec;

    always_comb begin
        set_vec           = '0;
        set_vec[EV_FRAME] = set_frame;
        set_vec[EV_BUF]   = set_buf;
        clr_vec           = clr_we ? clr_data : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ev_q   <= '0;
            mask_q <= '0;
        end else begin
            ev_q <= (ev_q & ~clr_vec) | set_vec;
            if (mask_we) mask_q <= mask_data;
        end
    end

    assign irq = |(ev_q & mask_q);
endmodule

// File: rtl/txr_walker.sv
module txr_walker
    import txr_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             doorbell,
    input  logic             cur_ready,
    input  logic [4:0]       cur_ctrl,
    input  logic [15:0]      cur_len,
    input  logic [31:0]      cur_addr,
    input  logic             snd_ready,
    input  logic             cmp_valid,
    input  logic [5:0]       cmp_flags,
    output txr_state_e       state_q,
    output logic [IDX_W-1:0] idx_q,
    output logic             snd_valid,
    output logic [31:0]      snd_addr,
    output logic [15:0]      snd_len,
    output logic             snd_last,
    output logic             snd_crc,
    output logic             wb_we,
    output logic [15:0]      wb_status,
    output logic             ev_frame,
    output logic             ev_buf
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);
    localparam int CW = SB_WRAP - CTRL_LO;
    localparam int CI = SB_IRQ  - CTRL_LO;
    localparam int CL = SB_LAST - CTRL_LO;
    localparam int CC = SB_CRC  - CTRL_LO;

    txr_state_e       state_d;
    logic             kick_q;
    logic [4:0]       lat_ctrl;
    logic [15:0]      lat_len;
    logic [31:0]      lat_addr;
    logic [5:0]       lat_flags;
    logic [IDX_W-1:0] idx_next;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (kick_q)    state_d = ST_SCAN;
            ST_SCAN:  state_d = cur_ready ? ST_SEND : ST_IDLE;
            ST_SEND:  if (snd_ready) state_d = ST_WAIT;
            ST_WAIT:  if (cmp_valid) state_d = ST_WBACK;
            ST_WBACK: state_d = ST_SCAN;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        if (lat_ctrl[CW] || idx_q == LAST_IDX) idx_next = '0;
        else                                   idx_next = idx_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            idx_q     <= '0;
            kick_q    <= 1'b0;
            lat_ctrl  <= '0;
            lat_len   <= '0;
            lat_addr  <= '0;
            lat_flags <= '0;
        end else begin
            state_q <= state_d;
            if (doorbell)                             kick_q <= 1'b1;
            else if (state_q == ST_IDLE && kick_q)    kick_q <= 1'b0;
            if (state_q == ST_SCAN && cur_ready) begin
                lat_ctrl <= cur_ctrl;
                lat_len  <= cur_len;
                lat_addr <= cur_addr;
            end
            if (state_q == ST_WAIT && cmp_valid) lat_flags <= cmp_flags;
            if (state_q == ST_WBACK)             idx_q     <= idx_next;
        end
    end

    always_comb begin
        snd_valid = (state_q == ST_SEND);
        snd_addr  = lat_addr;
        snd_len   = lat_len;
        snd_last  = lat_ctrl[CL];
        snd_crc   = lat_ctrl[CC];
        wb_we     = (state_q == ST_WBACK);
        wb_status = {1'b0, lat_ctrl, lat_flags[5:1], 3'b000, lat_flags[0], 1'b0};
        ev_frame  = wb_we && lat_ctrl[CI] && lat_ctrl[CL];
        ev_buf    = wb_we && lat_ctrl[CI] && !lat_ctrl[CL];
    end
endmodule

// File: rtl/txbd_ring_engine.sv
module txbd_ring_engine
    import txr_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int IDX_W   = $clog2(DEPTH),
    parameter int HADDR_W = IDX_W + 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               host_we,
    input  logic [HADDR_W-1:0] host_addr,
    input  logic [31:0]        host_wdata,
    input  logic [HADDR_W-1:0] host_raddr,
    output logic [31:0]        host_rdata,
    output logic               snd_valid,
    input  logic               snd_ready,
    output logic [31:0]        snd_addr,
    output logic [15:0]        snd_len,
    output logic               snd_last,
    output logic               snd_crc,
    input  logic               cmp_valid,
    input  logic [5:0]         cmp_flags,
    output logic [IDX_W-1:0]   ring_idx,
    output logic               irq
);
    localparam int OFF_W = HADDR_W - 1;

    logic             w_is_ctrl, r_is_ctrl;
    logic [OFF_W-1:0] w_off, r_off;
    logic             desc_we, bell, clr_we, mask_we;
    logic [31:0]      desc_rdata, ev_q, mask_q;
    logic [5:0]       e_ctrl;
    logic [15:0]      e_len, wb_status;
    logic [31:0]      e_addr;
    logic             wb_we, ev_frame, ev_buf;
    txr_state_e       fsm_state;

    always_comb begin
        w_is_ctrl = host_addr[HADDR_W-1];
        w_off     = host_addr[OFF_W-1:0];
        r_is_ctrl = host_raddr[HADDR_W-1];
        r_off     = host_raddr[OFF_W-1:0];
        desc_we   = host_we && !w_is_ctrl;
        clr_we    = host_we && w_is_ctrl && w_off == OFF_W'(CR_EVENT);
        mask_we   = host_we && w_is_ctrl && w_off == OFF_W'(CR_MASK);
        bell      = host_we && w_is_ctrl && w_off == OFF_W'(CR_BELL);
        if (!r_is_ctrl)                    host_rdata = desc_rdata;
        else if (r_off == OFF_W'(CR_EVENT)) host_rdata = ev_q;
        else if (r_off == OFF_W'(CR_MASK))  host_rdata = mask_q;
        else                                host_rdata = '0;
    end

    txr_desc_mem #(.DEPTH(DEPTH), .IDX_W(IDX_W)) mem_i (
        .clk(clk), .rst(rst),
        .h_we(desc_we), .h_idx(host_addr[IDX_W:1]), .h_word(host_addr[0]),
        .h_wdata(host_wdata),
        .h_ridx(host_raddr[IDX_W:1]), .h_rword(host_raddr[0]), .h_rdata(desc_rdata),
        .e_we(wb_we), .e_idx(ring_idx), .e_status(wb_status),
        .e_ctrl(e_ctrl), .e_len(e_len), .e_addr(e_addr)
    );

    txr_walker #(.DEPTH(DEPTH), .IDX_W(IDX_W)) walk_i (
        .clk(clk), .rst(rst), .doorbell(bell),
        .cur_ready(e_ctrl[5]), .cur_ctrl(e_ctrl[4:0]),
        .cur_len(e_len), .cur_addr(e_addr),
        .snd_ready(snd_ready), .cmp_valid(cmp_valid), .cmp_flags(cmp_flags),
        .state_q(fsm_state), .idx_q(ring_idx),
        .snd_valid(snd_valid), .snd_addr(snd_addr), .snd_len(snd_len),
        .snd_last(snd_last), .snd_crc(snd_crc),
        .wb_we(wb_we), .wb_status(wb_status),
        .ev_frame(ev_frame), .ev_buf(ev_buf)
    );

    txr_events ev_i (
        .clk(clk), .rst(rst),
        .set_frame(ev_frame), .set_buf(ev_buf),
        .clr_we(clr_we), .clr_data(host_wdata),
        .mask_we(mask_we), .mask_data(host_wdata),
        .ev_q(ev_q), .mask_q(mask_q), .irq(irq)
    );
endmodule

// File: rtl/txr_checker.sv
module txr_checker
    import txr_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             snd_valid,
    input logic             snd_ready,
    input logic [31:0]      snd_addr,
    input logic [15:0]      snd_len,
    input logic             irq,
    input logic [IDX_W-1:0] ring_idx,
    input logic [31:0]      ev_q,
    input logic [31:0]      mask_q,
    input txr_state_e       state
);
    localparam logic [31:0] EV_ALLOWED = (32'd1 << EV_FRAME) | (32'd1 << EV_BUF);

    // R1: clean state right after reset
    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ring_idx == '0 && !snd_valid && !irq && ev_q == '0));

    // R11: offer held until accepted
    a_r11_send_hold: assert property (@(posedge clk) disable iff (rst)
        (snd_valid && !snd_ready) |=> (snd_valid && $stable(snd_addr) && $stable(snd_len)));

    // R6: index only steps by one or returns to base
    a_r6_index_step: assert property (@(posedge clk) disable iff (rst)
        !$stable(ring_idx) |-> (ring_idx == '0 || ring_idx == $past(ring_idx) + 1'b1));

    // R6 / R4: index moves only on a write-back
    a_r6_index_on_wb: assert property (@(posedge clk) disable iff (rst)
        !$stable(ring_idx) |-> $past(state) == ST_WBACK);

    // R8: only the two defined event bits can be set
    a_r8_event_bits: assert property (@(posedge clk) disable iff (rst)
        (ev_q & ~EV_ALLOWED) == '0);

    // R8: frame event appears only after a write-back
    a_r8_frame_from_wb: assert property (@(posedge clk) disable iff (rst)
        $rose(ev_q[EV_FRAME]) |-> $past(state) == ST_WBACK);

    // R10: interrupt needs an enabled pending event
    a_r10_irq_source: assert property (@(posedge clk) disable iff (rst)
        irq |-> (ev_q & mask_q) != '0);
endmodule

bind txbd_ring_engine txr_checker #(.IDX_W(IDX_W)) chk_i (
    .clk(clk), .rst(rst),
    .snd_valid(snd_valid), .snd_ready(snd_ready),
    .snd_addr(snd_addr), .snd_len(snd_len),
    .irq(irq), .ring_idx(ring_idx),
    .ev_q(ev_q), .mask_q(mask_q), .state(fsm_state)
);

// File: tb/txbd_ring_engine_tb_top.sv
module txbd_ring_engine_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH   = 16;
    localparam int IDX_W   = 4;
    localparam int HADDR_W = IDX_W + 2;
    localparam int NV      = 8;

    // ctrl = {wrap, int, last, crc}; flags = {hb, lc, rl, un, cs, def}
    localparam logic [3:0]  V_CTRL  [NV] = '{4'b0111, 4'b0100, 4'b0011, 4'b1111,
                                            4'b0110, 4'b0001, 4'b0101, 4'b0010};
    localparam logic [15:0] V_LEN   [NV] = '{16'd64, 16'd1518, 16'd60, 16'd1,
                                            16'd2048, 16'd100, 16'd0, 16'hFFFF};
    localparam logic [31:0] V_ADDR  [NV] = '{32'h1000_0000, 32'h1000_0800, 32'h2000_0040, 32'hDEAD_BEE0,
                                            32'h0000_0004, 32'hFFFF_FFF0, 32'h1234_5678, 32'h8000_0000};
    localparam logic [5:0]  V_FLAGS [NV] = '{6'b000000, 6'b100001, 6'b010010, 6'b001100,
                                            6'b000001, 6'b111110, 6'b000000, 6'b100000};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic host_we = 1'b0;
    logic [HADDR_W-1:0] host_addr = '0, host_raddr = '0;
    logic [31:0] host_wdata = '0, host_rdata;
    logic snd_valid, snd_ready = 1'b0, snd_last, snd_crc;
    logic [31:0] snd_addr;
    logic [15:0] snd_len;
    logic cmp_valid = 1'b0;
    logic [5:0] cmp_flags = '0;
    logic [IDX_W-1:0] ring_idx;
    logic irq;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    txbd_ring_engine #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst(rst),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_raddr(host_raddr), .host_rdata(host_rdata),
        .snd_valid(snd_valid), .snd_ready(snd_ready),
        .snd_addr(snd_addr), .snd_len(snd_len),
        .snd_last(snd_last), .snd_crc(snd_crc),
        .cmp_valid(cmp_valid), .cmp_flags(cmp_flags),
        .ring_idx(ring_idx), .irq(irq)
    );

    function automatic logic [HADDR_W-1:0] d_addr(input int idx, input bit word);
        return {1'b0, IDX_W'(idx), word};
    endfunction

    function automatic logic [HADDR_W-1:0] c_addr(input int off);
        return {1'b1, (HADDR_W-1)'(off)};
    endfunction

    function automatic logic [15:0] armed(input logic [3:0] c);
        return {1'b1, 1'b0, c, 10'b0};
    endfunction

    function automatic logic [15:0] done_st(input logic [3:0] c, input logic [5:0] f);
        return {1'b0, 1'b0, c, f[5:1], 3'b000, f[0], 1'b0};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic hwrite(input logic [HADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic hread(input logic [HADDR_W-1:0] a, output logic [31:0] d);
        host_raddr = a;
        #1;
        d = host_rdata;
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // sender model: wait for an offer, accept it, then report completion
    task automatic serve(input logic [5:0] f, output logic [31:0] a, output logic [15:0] l,
                         output logic lst, output logic crc, output bit got);
        got = 0;
        for (int i = 0; i < 100 && !got; i++) begin
            @(negedge clk);
            if (snd_valid) got = 1;
        end
        a = snd_addr; l = snd_len; lst = snd_last; crc = snd_crc;
        if (got) begin
            idle_cycles(2);                 // hold off to exercise the stall
            snd_ready = 1'b1;
            @(negedge clk);
            snd_ready = 1'b0;
            idle_cycles(1);
            cmp_valid = 1'b1; cmp_flags = f;
            @(negedge clk);
            cmp_valid = 1'b0; cmp_flags = '0;
        end
    endtask

    task automatic watch_no_send(input int n, output bit seen);
        seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (snd_valid) seen = 1;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd, a;
        logic [15:0] l;
        logic lst, crc;
        bit got, seen;
        int exp_idx;
        logic [31:0] exp_ev;

        idle_cycles(3);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check("R1 ring_idx", 32'(ring_idx), 32'd0);
        check("R1 irq", 32'(irq), 32'd0);
        check("R1 snd_valid", 32'(snd_valid), 32'd0);
        hread(c_addr(0), rd); check("R1 events", rd, 32'd0);
        hread(d_addr(0, 0), rd); check("R1 status entry0", rd, 32'd0);
        hread(d_addr(DEPTH-1, 0), rd); check("R1 status last entry", rd, 32'd0);

        hwrite(c_addr(1), 32'd1 << 27);          // mask frame event only
        exp_idx = 0;

        // table walk: R3, R5, R6, R8, R9, R10
        for (int v = 0; v < NV; v++) begin
            hwrite(d_addr(exp_idx, 1), V_ADDR[v]);
            hwrite(d_addr(exp_idx, 0), {armed(V_CTRL[v]), V_LEN[v]});
            hwrite(c_addr(2), 32'hA5A5_0000 + 32'(v));   // any value rings the doorbell
            serve(V_FLAGS[v], a, l, lst, crc, got);
            check("R3 offer seen", 32'(got), 32'd1);
            check("R3 snd_addr", a, V_ADDR[v]);
            check("R3 snd_len", 32'(l), 32'(V_LEN[v]));
            check("R3 snd_last", 32'(lst), 32'(V_CTRL[v][1]));
            check("R3 snd_crc", 32'(crc), 32'(V_CTRL[v][0]));
            idle_cycles(4);
            hread(d_addr(exp_idx, 0), rd);
            check("R5 status writeback", rd, {done_st(V_CTRL[v], V_FLAGS[v]), V_LEN[v]});
            hread(d_addr(exp_idx, 1), rd);
            check("R5 address kept", rd, V_ADDR[v]);
            exp_ev = !V_CTRL[v][2] ? 32'd0 : (V_CTRL[v][1] ? (32'd1 << 27) : (32'd1 << 26));
            hread(c_addr(0), rd); check("R8 event", rd, exp_ev);
            check("R10 irq masked", 32'(irq), 32'(exp_ev[27]));
            exp_idx = V_CTRL[v][3] ? 0 : (exp_idx + 1) % DEPTH;
            check("R6 ring_idx", 32'(ring_idx), 32'(exp_idx));
            hwrite(c_addr(0), 32'hFFFF_FFFF);
            hread(c_addr(0), rd); check("R9 events cleared", rd, 32'd0);
        end

        // R4: entry not ready, doorbell does nothing
        hwrite(d_addr(exp_idx, 0), {16'h3800, 16'd77});   // wrap/int/last set, ready clear
        hwrite(c_addr(2), 32'd0);
        watch_no_send(12, seen);
        check("R4 no send on non-ready", 32'(seen), 32'd0);
        check("R4 index unchanged", 32'(ring_idx), 32'(exp_idx));
        hread(d_addr(exp_idx, 0), rd); check("R4 entry untouched", rd, {16'h3800, 16'd77});

        // R2: armed without doorbell stays put
        hwrite(d_addr(exp_idx, 1), 32'hCAFE_0000);
        hwrite(d_addr(exp_idx, 0), {armed(4'b0100), 16'd200});  // int, not last
        watch_no_send(20, seen);
        check("R2 no send without doorbell", 32'(seen), 32'd0);
        hread(d_addr(exp_idx, 0), rd); check("R2 still ready", rd, {armed(4'b0100), 16'd200});
        hwrite(d_addr((exp_idx+1)%DEPTH, 1), 32'hCAFE_1000);
        hwrite(d_addr((exp_idx+1)%DEPTH, 0), {armed(4'b0110), 16'd300}); // int + last
        hwrite(c_addr(2), 32'hFFFF_FFFF);
        serve(6'b0, a, l, lst, crc, got);
        check("R2 sent after doorbell", a, 32'hCAFE_0000);
        serve(6'b0, a, l, lst, crc, got);
        check("R7 second entry follows", a, 32'hCAFE_1000);
        idle_cycles(4);
        exp_idx = (exp_idx + 2) % DEPTH;
        hread(c_addr(0), rd); check("R8 both events", rd, (32'd1 << 27) | (32'd1 << 26));

        // R9 selective clear, R10 masking
        hwrite(c_addr(0), 32'd1 << 26);
        hread(c_addr(0), rd); check("R9 clear one bit", rd, 32'd1 << 27);
        hwrite(c_addr(1), 32'd1 << 26);
        @(negedge clk); check("R10 irq off by mask", 32'(irq), 32'd0);
        hwrite(c_addr(1), 32'hFFFF_FFFF);
        @(negedge clk); check("R10 irq on", 32'(irq), 32'd1);
        hwrite(c_addr(0), 32'hFFFF_FFFF);
        @(negedge clk); check("R10 irq after clear", 32'(irq), 32'd0);

        // R7 / R6: completely full ring, one doorbell, crosses physical end
        for (int k = 0; k < DEPTH; k++) begin
            hwrite(d_addr(k, 1), 32'h4000_0000 + 32'(k));
            hwrite(d_addr(k, 0), {armed(4'b0010), 16'(k + 1)});
        end
        hwrite(c_addr(2), 32'd1);
        for (int k = 0; k < DEPTH; k++) begin
            serve(6'b000001, a, l, lst, crc, got);
            check("R7 full ring order", a, 32'h4000_0000 + 32'((exp_idx + k) % DEPTH));
        end
        watch_no_send(10, seen);
        check("R7 stops after ring drained", 32'(seen), 32'd0);
        check("R6 back at start", 32'(ring_idx), 32'(exp_idx));
        for (int k = 0; k < DEPTH; k++) begin
            hread(d_addr(k, 0), rd);
            check("R7 entry released", rd, {done_st(4'b0010, 6'b000001), 16'(k + 1)});
        end
        hread(c_addr(0), rd); check("R8 no event without int flag", rd, 32'd0);

        // R1: reset mid-ring
        @(negedge clk); rst = 1'b1;
        idle_cycles(2); rst = 1'b0;
        @(negedge clk);
        check("R1 idx after reset", 32'(ring_idx), 32'd0);
        hread(d_addr(3, 0), rd); check("R1 status cleared", rd, 32'd0);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule